// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. A one-entry holding register takes each byte. The byte moves into a shift register when the line is free. An empty flag tells the host when it may write again. The frame shape comes from configuration inputs held steady by the surrounding logic: the data bit count (5 to 8), the parity mode, and one or two stop bits. All timing is counted in ticks of an enable pulse that runs at sixteen times the bit rate.

Three line modes sit on top of normal sending. A high clear-to-send input forces the line to mark at once and drops the frame in progress. The pending byte is kept. In echo mode the line repeats the receive input, delayed by half a bit time. It shows mark while an overrun is flagged. A continuous break mode sends whole frames of space for as long as it is held. The last break frame always runs to its end. It is followed by one mark bit before normal data resumes.

Top module: `sertx_core`

## Requirements
- R1: A synchronous reset drives txd high and tdre high, and drops any frame in progress.
- R2: A data frame is a start bit (0), then the low 5+wlen_sel data bits LSB first, then an optional parity bit, then stop bits (1). Each bit lasts 16 ticks. Between frames the line idles at 1.
- R3: With par_en set, the parity bit covers only the data bits sent. par_code 00 gives odd parity, 01 gives even parity, 10 gives a constant 1 and 11 gives a constant 0.
- R4: With two_stop clear there is one stop bit (16 ticks). With two_stop set there are two stop bits, with two exceptions: 5 data bits without parity give 1.5 stop bits (24 ticks), and 8 data bits with parity give one stop bit. A byte already waiting starts on the tick that ends the previous frame, so the start-to-start spacing equals the frame length.
- R5: tdre falls in the clock after a host write. It rises in the clock after the tick that moves the held byte into the shift register. When the line is idle, that is the first tick after the write.
- R6: While cts_n is high, txd is 1 from the next clock. The frame in progress is abandoned and a held byte is not consumed. After cts_n falls, the held byte starts on the next tick.
- R7: With echo_en set, txd follows rxd delayed by 8 ticks. A change on rxd reaches txd one clock after the 8th tick that follows it.
- R8: With echo_en set and echo_ovr high, txd is 1 from the next clock. Echo resumes when echo_ovr falls.
- R9: While echo_en is set, the transmitter sends nothing and a held byte stays pending (tdre stays 0).
- R10: While brk_en is set, the line is held at 0 in whole frame lengths, starting at the next frame boundary. This takes priority over a held byte.
- R11: When brk_en clears, the current break frame still runs to its full length. One 16-tick mark bit follows it, and then the held byte starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_MAX | Byte to send |
| wlen_sel | input | 2 | Data bit count minus 5 |
| two_stop | input | 1 | Selects the longer stop period |
| par_en | input | 1 | Adds a parity bit |
| par_code | input | 2 | Parity kind: odd, even, constant 1, constant 0 |
| brk_en | input | 1 | Continuous break request |
| echo_en | input | 1 | Echo mode: txd repeats rxd |
| cts_n | input | 1 | Clear to send, active low |
| rxd | input | 1 | Receive line used by echo mode |
| echo_ovr | input | 1 | Receiver overrun; forces mark during echo |
| txd | output | 1 | Serial output line |
| tdre | output | 1 | Holding register empty |

## Verification
Each txd change is due one clock after the state change that causes it. A frame's start bit therefore appears one clock after the loading tick, and each bit covers 32 clocks at the bench's tick rate. The bench finds each falling start edge and samples every bit at its middle. It judges stop length from the exact start-to-start spacing of two queued frames. tdre is checked on the negedge after the write edge and again after the loading tick. The echo delay is checked on both negedges that follow the 8th tick, so it must be exactly 8 ticks plus one clock. The clear-to-send and overrun overrides are due on the first negedge after they are raised.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   // parity selection codes as seen on par_code
   typedef enum logic [1:0] {
      PAR_ODD  = 2'b00,
      PAR_EVEN = 2'b01,
      PAR_ONE  = 2'b10,
      PAR_ZERO = 2'b11
   } par_code_e;

   // what the shift register is currently sending
   typedef enum logic [1:0] {
      FK_IDLE  = 2'b00,
      FK_DATA  = 2'b01,
      FK_BREAK = 2'b10,
      FK_MARK  = 2'b11
   } frame_kind_e;

   typedef struct packed {
      logic [1:0] wlen;
      logic       two_stop;
      logic       par_en;
      logic [1:0] par_code;
   } line_cfg_t;

endpackage

// File: rtl/sertx_framer.sv
module sertx_framer
   import sertx_pkg::*;
#(
   parameter int DATA_MAX = 8,
   parameter int OVS      = 16,
   localparam int SH_W    = DATA_MAX + 2,
   localparam int TW      = $clog2(OVS * (DATA_MAX + 4) + 1)
) (
   input  line_cfg_t            cfg,
   input  logic [DATA_MAX-1:0]  data,
   output logic [SH_W-1:0]      bits,
   output logic [TW-1:0]        ticks
);

   localparam int DATA_MIN = DATA_MAX - 3;

   always_comb begin
      int                  nd;
      int                  stop_t;
      logic [DATA_MAX-1:0] msk;
      logic                p;

      nd = DATA_MIN + int'(cfg.wlen);

      msk = '0;
      for (int i = 0; i < DATA_MAX; i++) begin
         if (i < nd) msk[i] = data[i];
      end

      case (par_code_e'(cfg.par_code))
         PAR_ODD:  p = ~(^msk);
         PAR_EVEN: p = ^msk;
         PAR_ONE:  p = 1'b1;
         default:  p = 1'b0;
      endcase

      // bit 0 is the start bit; positions above the payload stay 1 (stop)
      bits    = '1;
      bits[0] = 1'b0;
      for (int i = 0; i < DATA_MAX; i++) begin
         if (i < nd) bits[i+1] = msk[i];
      end
      for (int k = 1; k < SH_W; k++) begin
         if (cfg.par_en && (k == nd + 1)) bits[k] = p;
      end

      if (!cfg.two_stop)                       stop_t = OVS;
      else if (nd == DATA_MIN && !cfg.par_en)  stop_t = OVS + OVS / 2;
      else if (nd == DATA_MAX && cfg.par_en)   stop_t = OVS;
      else                                     stop_t = 2 * OVS;

      ticks = TW'(OVS * (1 + nd + int'(cfg.par_en)) + stop_t);
   end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int OVS  = 16,
   parameter int SH_W = 10,
   parameter int TW   = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             halt,
   input  logic             brk_req,
   input  logic             hold_full,
   input  logic [SH_W-1:0]  load_bits,
   input  logic [TW-1:0]    load_ticks,
   output logic             line,
   output logic             take,
   output frame_kind_e      kind
);

   localparam int PW = $clog2(OVS);

   frame_kind_e     kind_q;
   logic [SH_W-1:0] sh_q;
   logic [TW-1:0]   rem_q;
   logic [PW-1:0]   ph_q;

   logic busy, frame_end, slot, to_mark, to_break, to_data, fill;

   assign busy      = (kind_q != FK_IDLE);
   assign frame_end = busy && tick && (rem_q == TW'(1));
   assign slot      = tick && !halt && (!busy || frame_end);
   assign to_mark   = slot && frame_end && (kind_q == FK_BREAK) && !brk_req;
   assign to_break  = slot && !to_mark && brk_req;
   assign to_data   = slot && !to_mark && !brk_req && hold_full;
   assign fill      = (kind_q != FK_BREAK);

   always_ff @(posedge clk) begin
      if (rst || halt) begin
         kind_q <= FK_IDLE;
         sh_q   <= '1;
         rem_q  <= '0;
         ph_q   <= '0;
      end else if (to_mark) begin
         kind_q <= FK_MARK;
         sh_q   <= '1;
         rem_q  <= TW'(OVS);
         ph_q   <= '0;
      end else if (to_break) begin
         kind_q <= FK_BREAK;
         sh_q   <= '0;
         rem_q  <= load_ticks;
         ph_q   <= '0;
      end else if (to_data) begin
         kind_q <= FK_DATA;
         sh_q   <= load_bits;
         rem_q  <= load_ticks;
         ph_q   <= '0;
      end else if (frame_end) begin
         kind_q <= FK_IDLE;
         sh_q   <= '1;
         rem_q  <= '0;
         ph_q   <= '0;
      end else if (busy && tick) begin
         rem_q <= rem_q - TW'(1);
         ph_q  <= ph_q + PW'(1);
         if (ph_q == PW'(OVS - 1)) sh_q <= {fill, sh_q[SH_W-1:1]};
      end
   end

   assign line = sh_q[0];
   assign take = to_data;
   assign kind = kind_q;

endmodule

// File: rtl/sertx_echo_line.sv
module sertx_echo_line #(
   parameter int DEPTH = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic rxd,
   output logic echo_bit
);

   logic [DEPTH-1:0] st_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst)       st_q[g] <= 1'b1;
            else if (tick) st_q[g] <= rxd;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst)       st_q[g] <= 1'b1;
            else if (tick) st_q[g] <= st_q[g-1];
         end
      end
   end

   assign echo_bit = st_q[DEPTH-1];

endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int OVS      = 16,
   parameter int DATA_MAX = 8,
   parameter bit ECHO_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                tick16,
   input  logic                wr_en,
   input  logic [DATA_MAX-1:0] wr_data,
   input  logic [1:0]          wlen_sel,
   input  logic                two_stop,
   input  logic                par_en,
   input  logic [1:0]          par_code,
   input  logic                brk_en,
   input  logic                echo_en,
   input  logic                cts_n,
   input  logic                rxd,
   input  logic                echo_ovr,
   output logic                txd,
   output logic                tdre
);

   localparam int SH_W       = DATA_MAX + 2;
   localparam int TW         = $clog2(OVS * (DATA_MAX + 4) + 1);
   localparam int ECHO_DEPTH = OVS / 2;

   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 4");
   end
   if (DATA_MAX < 4 || DATA_MAX > 16) begin : g_bad_width
      $error("DATA_MAX must lie in 4..16");
   end

   logic [DATA_MAX-1:0] hold_q;
   logic                full_q;
   logic                take;
   logic                line;
   logic                echo_bit;
   logic                halt;
   logic [SH_W-1:0]     frame_bits;
   logic [TW-1:0]       frame_ticks;
   frame_kind_e         frame_kind;
   line_cfg_t           cfg;
   logic                txd_q;

   assign cfg  = '{wlen: wlen_sel, two_stop: two_stop, par_en: par_en, par_code: par_code};
   assign halt = cts_n | echo_en;

   // one-entry holding register
   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
         full_q <= 1'b0;
      end else if (wr_en) begin
         hold_q <= wr_data;
         full_q <= 1'b1;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end

   sertx_framer #(
      .DATA_MAX (DATA_MAX),
      .OVS      (OVS)
   ) u_framer (
      .cfg   (cfg),
      .data  (hold_q),
      .bits  (frame_bits),
      .ticks (frame_ticks)
   );

   sertx_shifter #(
      .OVS  (OVS),
      .SH_W (SH_W),
      .TW   (TW)
   ) u_shift (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick16),
      .halt       (halt),
      .brk_req    (brk_en),
      .hold_full  (full_q),
      .load_bits  (frame_bits),
      .load_ticks (frame_ticks),
      .line       (line),
      .take       (take),
      .kind       (frame_kind)
   );

   if (ECHO_EN) begin : g_echo
      sertx_echo_line #(
         .DEPTH (ECHO_DEPTH)
      ) u_echo (
         .clk      (clk),
         .rst      (rst),
         .tick     (tick16),
         .rxd      (rxd),
         .echo_bit (echo_bit)
      );
   end else begin : g_no_echo
      assign echo_bit = 1'b1;
   end

   // registered line driver: overrides first, then echo, then the shifter
   always_ff @(posedge clk) begin
      if (rst)          txd_q <= 1'b1;
      else if (cts_n)   txd_q <= 1'b1;
      else if (echo_en) txd_q <= echo_ovr ? 1'b1 : echo_bit;
      else              txd_q <= line;
   end

   assign txd  = txd_q;
   assign tdre = !full_q;

endmodule

// File: rtl/sertx_checks.sv
module sertx_checks
   import sertx_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       tick16,
   input logic       wr_en,
   input logic       cts_n,
   input logic       echo_en,
   input logic       echo_ovr,
   input logic       txd,
   input logic       tdre,
   input logic [1:0] kind
);

   assert_cts_mark_R6: assert property (@(posedge clk) disable iff (rst)
      cts_n |=> txd);

   assert_write_clears_R5: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !tdre);

   assert_empty_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(tdre)) |-> $past(tick16));

   assert_overrun_mark_R8: assert property (@(posedge clk) disable iff (rst)
      (echo_en && echo_ovr) |=> txd);

   assert_echo_holds_R9: assert property (@(posedge clk) disable iff (rst)
      (echo_en && !wr_en) |=> (tdre == $past(tdre)));

   assert_break_space_R10: assert property (@(posedge clk) disable iff (rst)
      (kind == FK_BREAK && !cts_n && !echo_en) |=> !txd);

endmodule

bind sertx_core sertx_checks u_checks (
   .clk      (clk),
   .rst      (rst),
   .tick16   (tick16),
   .wr_en    (wr_en),
   .cts_n    (cts_n),
   .echo_en  (echo_en),
   .echo_ovr (echo_ovr),
   .txd      (txd),
   .tdre     (tdre),
   .kind     (frame_kind)
);

// File: tb/sertx_core_bench.sv
module sertx_core_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick16 = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] wlen_sel = 2'd3;
   logic       two_stop = 1'b0;
   logic       par_en = 1'b0;
   logic [1:0] par_code = 2'd0;
   logic       brk_en = 1'b0;
   logic       echo_en = 1'b0;
   logic       cts_n = 1'b0;
   logic       rxd = 1'b1;
   logic       echo_ovr = 1'b0;
   logic       txd;
   logic       tdre;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   sertx_core u_sertx_core (
      .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
      .wlen_sel(wlen_sel), .two_stop(two_stop), .par_en(par_en), .par_code(par_code),
      .brk_en(brk_en), .echo_en(echo_en), .cts_n(cts_n), .rxd(rxd),
      .echo_ovr(echo_ovr), .txd(txd), .tdre(tdre)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // tick high on every other rising edge: one bit = 32 clocks
   initial begin
      forever begin
         @(negedge clk);
         tick16 = ~tick16;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic wait_ticks(input int n);
      repeat (n) begin
         @(posedge clk);
         while (!tick16) @(posedge clk);
      end
   endtask

   task automatic at_cyc(input int k);
      while (cyc < k) @(negedge clk);
   endtask

   task automatic host_write(input logic [7:0] d);
      @(negedge clk);
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
      chk(tdre == 1'b0, "R5 tdre after write", int'(tdre), 0);
   endtask

   function automatic int nd_of();
      return 5 + int'(wlen_sel);
   endfunction

   function automatic int ft_of();
      int nd, st;
      nd = nd_of();
      if (!two_stop)              st = 16;
      else if (nd == 5 && !par_en) st = 24;
      else if (nd == 8 && par_en)  st = 16;
      else                         st = 32;
      return 16 * (1 + nd + int'(par_en)) + st;
   endfunction

   function automatic bit exp_bit(input logic [7:0] d, input int i);
      int nd, ones;
      bit p;
      nd = nd_of();
      ones = 0;
      for (int k = 0; k < nd; k++) ones += int'(d[k]);
      case (par_code)
         2'd0:    p = (ones % 2 == 0);
         2'd1:    p = (ones % 2 == 1);
         2'd2:    p = 1'b1;
         default: p = 1'b0;
      endcase
      if (i == 0) return 1'b0;
      if (i <= nd) return d[i-1];
      if (i == nd + 1 && par_en) return p;
      return 1'b1;
   endfunction

   // find the start edge, optionally queue a follow-up byte, then sample each bit mid-way
   task automatic check_frame(input logic [7:0] d, input bit do_wr, input logic [7:0] nxt,
                              output int t0);
      int lim, nbits;
      bit e;
      lim = 0;
      while (txd !== 1'b0 && lim < 5000) begin
         @(negedge clk);
         lim++;
      end
      t0 = cyc;
      if (do_wr) host_write(nxt);
      nbits = 2 + nd_of() + int'(par_en);
      for (int i = 0; i < nbits; i++) begin
         at_cyc(t0 + 32 * i + 16);
         e = exp_bit(d, i);
         if (par_en && i == nd_of() + 1)
            chk(txd == e, "R3 parity bit", int'(txd), int'(e));
         else
            chk(txd == e, "R2 frame bit", int'(txd), int'(e));
      end
   endtask

   initial begin
      int t0, t1, t2, idx;
      logic [7:0] d1, d2;

      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
      chk(tdre == 1'b1, "R1 tdre after reset", int'(tdre), 1);

      // sweep every word length, parity choice and stop setting
      idx = 0;
      for (int wl = 0; wl < 4; wl++) begin
         for (int pc = 0; pc < 5; pc++) begin
            for (int ts = 0; ts < 2; ts++) begin
               @(negedge clk);
               wlen_sel = 2'(wl);
               par_en   = (pc != 4);
               par_code = 2'(pc % 4);
               two_stop = 1'(ts);
               d1 = 8'(8'h35 + idx * 29);
               d2 = 8'(8'hC9 ^ (idx * 53));
               idx++;
               host_write(d1);
               wait_ticks(1);
               @(negedge clk);
               chk(tdre == 1'b1, "R5 tdre after load tick", int'(tdre), 1);
               check_frame(d1, 1'b1, d2, t0);
               check_frame(d2, 1'b0, 8'h00, t1);
               chk(t1 - t0 == 2 * ft_of(), "R4 start spacing", t1 - t0, 2 * ft_of());
               at_cyc(t1 + 2 * ft_of() + 20);
               chk(txd == 1'b1, "R2 idle line", int'(txd), 1);
               chk(tdre == 1'b1, "R5 empty when done", int'(tdre), 1);
            end
         end
      end

      // clear-to-send abort and resume, 8 bits, no parity, one stop
      @(negedge clk);
      wlen_sel = 2'd3; par_en = 1'b0; par_code = 2'd0; two_stop = 1'b0;
      host_write(8'hC3);
      while (txd !== 1'b0) @(negedge clk);
      t0 = cyc;
      at_cyc(t0 + 32 * 3 + 16);
      cts_n = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1, "R6 mark on cts", int'(txd), 1);
      host_write(8'h5A);
      wait_ticks(30);
      @(negedge clk);
      chk(tdre == 1'b0, "R6 byte held", int'(tdre), 0);
      chk(txd == 1'b1, "R6 line mark", int'(txd), 1);
      cts_n = 1'b0;
      check_frame(8'h5A, 1'b0, 8'h00, t1);
      at_cyc(t1 + 2 * ft_of() + 10);
      chk(tdre == 1'b1, "R6 sent after cts", int'(tdre), 1);

      // echo delay, overrun override, transmitter held off
      @(negedge clk);
      echo_en = 1'b1;
      rxd = 1'b1;
      wait_ticks(10);
      @(negedge clk);
      chk(txd == 1'b1, "R7 echo idle", int'(txd), 1);
      rxd = 1'b0;
      wait_ticks(8);
      @(negedge clk);
      chk(txd == 1'b1, "R7 echo not early", int'(txd), 1);
      @(negedge clk);
      chk(txd == 1'b0, "R7 echo on time", int'(txd), 0);
      rxd = 1'b1;
      wait_ticks(8);
      @(negedge clk);
      chk(txd == 1'b0, "R7 echo rise not early", int'(txd), 0);
      @(negedge clk);
      chk(txd == 1'b1, "R7 echo rise on time", int'(txd), 1);
      host_write(8'h96);
      wait_ticks(40);
      @(negedge clk);
      chk(tdre == 1'b0, "R9 byte held in echo", int'(tdre), 0);
      chk(txd == 1'b1, "R9 no frame in echo", int'(txd), 1);
      rxd = 1'b0;
      wait_ticks(10);
      @(negedge clk);
      chk(txd == 1'b0, "R7 echo space", int'(txd), 0);
      echo_ovr = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1, "R8 overrun mark", int'(txd), 1);
      echo_ovr = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(txd == 1'b0, "R8 echo resumes", int'(txd), 0);
      rxd = 1'b1;
      wait_ticks(10);
      @(negedge clk);
      echo_en = 1'b0;
      check_frame(8'h96, 1'b0, 8'h00, t1);
      at_cyc(t1 + 2 * ft_of() + 10);

      // continuous break, late cancel, trailing mark, then pending byte
      @(negedge clk);
      brk_en = 1'b1;
      while (txd !== 1'b0) @(negedge clk);
      t0 = cyc;
      at_cyc(t0 + 100);
      chk(txd == 1'b0, "R10 break space", int'(txd), 0);
      host_write(8'h3C);
      at_cyc(t0 + 480);
      chk(txd == 1'b0, "R10 continuous break", int'(txd), 0);
      chk(tdre == 1'b0, "R10 byte waits", int'(tdre), 0);
      at_cyc(t0 + 500);
      brk_en = 1'b0;
      at_cyc(t0 + 630);
      chk(txd == 1'b0, "R11 break completes", int'(txd), 0);
      at_cyc(t0 + 656);
      chk(txd == 1'b1, "R11 mark after break", int'(txd), 1);
      check_frame(8'h3C, 1'b0, 8'h00, t2);
      chk(t2 == t0 + 672, "R11 data after mark", t2 - t0, 672);
      at_cyc(t2 + 2 * ft_of() + 10);

      // reset in the middle of a frame
      host_write(8'h00);
      while (txd !== 1'b0) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(txd == 1'b1, "R1 txd after mid reset", int'(txd), 1);
      chk(tdre == 1'b1, "R1 tdre after mid reset", int'(tdre), 1);
      wait_ticks(40);
      @(negedge clk);
      chk(txd == 1'b1, "R1 frame dropped", int'(txd), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 190000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule